// File: doc/BRIEF.md
# Buffered Factory-Program Command Sequencer

This block sits between a host bus and the write port of a word-wide flash-style array. It runs a fast bulk-programming mode meant for production lines. The host opens the mode with a two-write handshake. It then streams data words in groups of 32. Each group is collected in an internal buffer. The sequencer then writes the group into the array one word at a time. After each word it reads the word back and compares it, and it rewrites the word when the read-back does not match.

During the mode the host places the same start address on every data write. The sequencer keeps its own array pointer and moves that pointer forward by one buffer after each group. The host can load any number of further groups without opening the mode again. A write to an address in a different 64K-word block ends the mode. Host reads always see an 8-bit status value, which shows whether the block can take a word, whether it is busy programming, and whether an error has latched.

Top module: `bfp_seq`

## Requirements
- R1: After reset, `status` is 0x80 and neither `arr_we` nor `arr_re` is asserted.
- R2: A write with low byte 0x80 in idle, followed by a write with low byte 0xD0, enters the program mode. Any other second byte sets status bit 4 (status 0x90) and returns to idle, where data writes start no array activity.
- R3: The first data write in the mode is checked before anything is programmed. If its address has nonzero bits [4:0], or if `blk_lock` is set for its block (address bits [19:16]), status bit 4 is set, the block returns to idle, and no array write occurs.
- R4: The 32 data words of a group are programmed in order. Word i goes to array address start+i. A data value of 0x0070 is programmed as ordinary data.
- R5: Status encoding is: bit 7 = 1 when not programming, bit 4 = error, bit 0 = 1 while programming the array, all other bits 0. While bit 0 is 1, host writes have no effect.
- R6: Every array write is followed in the next cycle by a read of the same address. On a mismatch the same word is written again, up to 3 retries. A word that verifies within that limit lets the group continue.
- R7: If a word still mismatches after 3 retries (4 writes in total), status bit 4 is set, the block returns to idle, and no further array writes occur.
- R8: After a group completes, status returns to 0x80. The next 32 writes with an in-block address program the next 32 array words (start+32 onward) without a new command.
- R9: A data write whose block differs from the start block leaves the mode. The partly filled group is dropped, status reads 0x80, and later data writes program nothing.
- R10: A write with low byte 0x50 in idle clears status bit 4. Without a host write, a set bit 4 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host bus write strobe, one cycle per write |
| host_addr | input | 20 | Host word address |
| host_wdata | input | 16 | Host write data or command byte (low byte) |
| blk_lock | input | 16 | Per-block protection, one bit per 64K-word block |
| status | output | 8 | Status value returned on host reads |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe; data is expected on `arr_rdata` one cycle later |
| arr_addr | output | 20 | Array word address |
| arr_wdata | output | 16 | Array write data |
| arr_rdata | input | 16 | Array read-back data |

## Verification
A wrong fill counter or pointer shows up at the array port on the first programmed word. The write that reaches the array has the wrong address or data, and the scoreboard reports it within a few cycles of the group filling. A stuck or wrong state shows up in `status` at the next sample after the host write that caused it, for example a missing error bit after a bad confirm or a busy bit that does not clear. Retry handling is checked by counting repeated writes to one address against the number of corrupted writes that were injected.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_FILL,
    S_LOAD,
    S_WR,
    S_RD,
    S_WAIT,
    S_CMP
  } bfp_state_t;

  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  function automatic logic is_busy(bfp_state_t s);
    return (s == S_LOAD) || (s == S_WR) || (s == S_RD) ||
           (s == S_WAIT) || (s == S_CMP);
  endfunction

  function automatic logic [7:0] status_of(bfp_state_t s, logic err);
    logic b;
    b = is_busy(s);
    return {~b, 2'b00, err, 3'b000, b};
  endfunction

endpackage

// File: rtl/bfp_wbuf.sv
module bfp_wbuf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end

endmodule

// File: rtl/bfp_addr.sv
module bfp_addr #(
  parameter int AW       = 20,
  parameter int BLK_BITS = 16,
  parameter int BUF_WORDS = 32,
  localparam int IW      = $clog2(BUF_WORDS),
  localparam int BW      = AW - BLK_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] host_addr,
  input  logic [IW-1:0] widx,
  output logic          same_blk,
  output logic          aligned,
  output logic [BW-1:0] host_blk,
  output logic [AW-1:0] word_addr
);

  logic [BW-1:0]       blk_q;
  logic [BLK_BITS-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
      off_q <= '0;
    end else if (load) begin
      blk_q <= host_addr[AW-1:BLK_BITS];
      off_q <= host_addr[BLK_BITS-1:0];
    end else if (adv) begin
      off_q <= off_q + BLK_BITS'(BUF_WORDS);
    end
  end

  assign host_blk  = host_addr[AW-1:BLK_BITS];
  assign same_blk  = (host_blk == blk_q);
  assign aligned   = (host_addr[IW-1:0] == '0);
  assign word_addr = {blk_q, off_q + {{(BLK_BITS-IW){1'b0}}, widx}};

endmodule

// File: rtl/bfp_seq.sv
module bfp_seq #(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int BLK_BITS  = 16,
  parameter int BUF_WORDS = 32,
  parameter int MAX_RETRY = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           host_wr,
  input  logic [AW-1:0]                  host_addr,
  input  logic [DW-1:0]                  host_wdata,
  input  logic [(1<<(AW-BLK_BITS))-1:0]  blk_lock,
  output logic [7:0]                     status,
  output logic                           arr_we,
  output logic                           arr_re,
  output logic [AW-1:0]                  arr_addr,
  output logic [DW-1:0]                  arr_wdata,
  input  logic [DW-1:0]                  arr_rdata
);
  import bfp_pkg::*;

  localparam int IW = $clog2(BUF_WORDS);
  localparam int BW = AW - BLK_BITS;
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(BUF_WORDS - 1);

  bfp_state_t    st, st_n;
  logic          err, err_n;
  logic          first, first_n;
  logic [IW-1:0] cnt, cnt_n;
  logic [IW-1:0] widx, widx_n;
  logic [RW-1:0] rc, rc_n;
  logic          buf_we, ld, adv, we_n, re_n;
  logic          same_blk, aligned;
  logic [BW-1:0] host_blk;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] buf_q;
  logic [7:0]    cmd;

  assign cmd = host_wdata[7:0];

  bfp_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) u_wbuf (
    .clk  (clk),
    .we   (buf_we),
    .widx (cnt),
    .wdata(host_wdata),
    .ridx (widx),
    .rdata(buf_q)
  );

  bfp_addr #(.AW(AW), .BLK_BITS(BLK_BITS), .BUF_WORDS(BUF_WORDS)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .adv      (adv),
    .host_addr(host_addr),
    .widx     (widx),
    .same_blk (same_blk),
    .aligned  (aligned),
    .host_blk (host_blk),
    .word_addr(word_addr)
  );

  always_comb begin
    st_n    = st;
    err_n   = err;
    first_n = first;
    cnt_n   = cnt;
    widx_n  = widx;
    rc_n    = rc;
    buf_we  = 1'b0;
    ld      = 1'b0;
    adv     = 1'b0;
    we_n    = 1'b0;
    re_n    = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (host_wr) begin
          if (cmd == CMD_SETUP)      st_n  = S_SETUP;
          else if (cmd == CMD_CLEAR) err_n = 1'b0;
        end
      end
      S_SETUP: begin
        if (host_wr) begin
          if (cmd == CMD_CONFIRM) begin
            st_n    = S_FILL;
            first_n = 1'b1;
            cnt_n   = '0;
          end else begin
            err_n = 1'b1;
            st_n  = S_IDLE;
          end
        end
      end
      S_FILL: begin
        if (host_wr) begin
          if (first) begin
            if (!aligned || blk_lock[host_blk]) begin
              err_n = 1'b1;
              st_n  = S_IDLE;
            end else begin
              ld      = 1'b1;
              buf_we  = 1'b1;
              first_n = 1'b0;
              cnt_n   = cnt + 1'b1;
            end
          end else if (!same_blk) begin
            st_n = S_IDLE;
          end else begin
            buf_we = 1'b1;
            if (cnt == LAST_IDX) begin
              st_n   = S_LOAD;
              cnt_n  = '0;
              widx_n = '0;
              rc_n   = '0;
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
      end
      S_LOAD: st_n = S_WR;
      S_WR: begin
        we_n = 1'b1;
        st_n = S_RD;
      end
      S_RD: begin
        re_n = 1'b1;
        st_n = S_WAIT;
      end
      S_WAIT: st_n = S_CMP;
      S_CMP: begin
        if (arr_rdata == buf_q) begin
          rc_n = '0;
          if (widx == LAST_IDX) begin
            adv  = 1'b1;
            st_n = S_FILL;
          end else begin
            widx_n = widx + 1'b1;
            st_n   = S_LOAD;
          end
        end else if (rc == RW'(MAX_RETRY)) begin
          err_n = 1'b1;
          st_n  = S_IDLE;
        end else begin
          rc_n = rc + 1'b1;
          st_n = S_WR;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      err       <= 1'b0;
      first     <= 1'b0;
      cnt       <= '0;
      widx      <= '0;
      rc        <= '0;
      status    <= status_of(S_IDLE, 1'b0);
      arr_we    <= 1'b0;
      arr_re    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      st        <= st_n;
      err       <= err_n;
      first     <= first_n;
      cnt       <= cnt_n;
      widx      <= widx_n;
      rc        <= rc_n;
      status    <= status_of(st_n, err_n);
      arr_we    <= we_n;
      arr_re    <= re_n;
      arr_addr  <= word_addr;
      arr_wdata <= buf_q;
    end
  end

endmodule

// File: rtl/bfp_seq_chk.sv
module bfp_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic [7:0]    status,
  input logic          arr_we,
  input logic          arr_re,
  input logic [AW-1:0] arr_addr
);

  AST_RESET_STATUS: assert property (@(posedge clk) $past(rst) |-> (status == 8'h80 && !arr_we && !arr_re)); // R1

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) arr_we |-> (status[0] && !status[7])); // R5

  AST_VERIFY_FOLLOWS: assert property (@(posedge clk) disable iff (rst) arr_we |=> arr_re); // R6

  AST_VERIFY_SAME_ADDR: assert property (@(posedge clk) disable iff (rst) arr_we |=> (arr_addr == $past(arr_addr))); // R6

  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(arr_we && arr_re)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (status[4] && !host_wr) |=> status[4]); // R10

endmodule

bind bfp_seq bfp_seq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .host_wr (host_wr),
  .status  (status),
  .arr_we  (arr_we),
  .arr_re  (arr_re),
  .arr_addr(arr_addr)
);

// File: tb/bfp_seq_test.sv
module bfp_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [15:0]   blk_lock = '0;
  logic [7:0]    status;
  logic          arr_we, arr_re;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] arr_rdata = '0;

  int total = 0;
  int bad = 0;
  int writes_seen = 0;
  bit done = 1'b0;

  logic [AW+DW-1:0] exp_q[$];
  logic [DW-1:0]    amem[int];
  logic [AW-1:0]    fault_addr = '0;
  int               fault_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfp_seq uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .blk_lock(blk_lock), .status(status),
    .arr_we(arr_we), .arr_re(arr_re), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // array model with injectable corrupt writes
  always @(posedge clk) begin
    if (arr_we) begin
      if (arr_addr == fault_addr && fault_left > 0) begin
        amem[int'(arr_addr)] = ~arr_wdata;
        fault_left = fault_left - 1;
      end else begin
        amem[int'(arr_addr)] = arr_wdata;
      end
    end
    if (arr_re)
      arr_rdata <= amem.exists(int'(arr_addr)) ? amem[int'(arr_addr)] : 16'hFFFF;
  end

  // monitor: pops expected array writes
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      writes_seen++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected array write actual=%h:%h expected=none", arr_addr, arr_wdata);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        if ({arr_addr, arr_wdata} !== e) begin
          bad++;
          $display("FAIL R4/R6 array write actual=%h:%h expected=%h:%h",
                   arr_addr, arr_wdata, e[AW+DW-1:DW], e[DW-1:0]);
        end
      end
    end
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 3000; i++) begin
      if (!status[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic enter(input logic [AW-1:0] a);
    hwrite(a, 16'h0080);
    hwrite(a, 16'h00D0);
  endtask

  // pushes expectations, then streams one group of words
  task automatic group(input logic [AW-1:0] host_a, input logic [AW-1:0] arr_base,
                       input logic [DW-1:0] dbase, input int fidx, input int nfail,
                       input bit put70);
    for (int i = 0; i < 32; i++) begin
      logic [DW-1:0] d;
      d = (put70 && i == 5) ? 16'h0070 : dbase + DW'(i);
      if (i == fidx) begin
        for (int k = 0; k <= nfail; k++) exp_q.push_back({arr_base + AW'(i), d});
      end else begin
        exp_q.push_back({arr_base + AW'(i), d});
      end
    end
    if (fidx >= 0) begin
      fault_addr = arr_base + AW'(fidx);
      fault_left = nfail;
    end
    for (int i = 0; i < 32; i++)
      hwrite(host_a, (put70 && i == 5) ? 16'h0070 : dbase + DW'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ws;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check8("R1 reset status", status, 8'h80);

    // wrong confirm
    hwrite(20'h20040, 16'h0080);
    hwrite(20'h20040, 16'h0033);
    check8("R2 bad confirm sets error", status, 8'h90);
    hwrite(20'h20040, 16'h1234);
    check8("R2 idle data ignored", status, 8'h90);
    hwrite(20'h00000, 16'h0050);
    check8("R10 clear status", status, 8'h80);

    // first group, includes read-status code as data
    enter(20'h20000);
    check8("R2 in mode ready", status, 8'h80);
    group(20'h20040, 20'h20040, 16'h1000, -1, 0, 1'b1);
    check8("R5 busy after full buffer", status, 8'h01);
    hwrite(20'h20040, 16'hDEAD);   // must be ignored while busy
    wait_ready();
    check8("R4 group done status", status, 8'h80);

    // second group, two corrupted writes on word 3
    group(20'h20040, 20'h20060, 16'h2000, 3, 2, 1'b0);
    wait_ready();
    check8("R6 R8 retry then continue", status, 8'h80);

    // exit via out-of-block write, partial group dropped
    hwrite(20'h20040, 16'h3001);
    hwrite(20'h20040, 16'h3002);
    hwrite(20'h20040, 16'h3003);
    hwrite(20'h30000, 16'h1111);
    check8("R9 exit status", status, 8'h80);
    ws = writes_seen;
    for (int i = 0; i < 32; i++) hwrite(20'h20040, 16'h4400 + 16'(i));
    repeat (10) @(negedge clk);
    check8("R9 no programming after exit", 8'(writes_seen - ws), 8'h00);

    // locked block
    blk_lock[5] = 1'b1;
    enter(20'h50000);
    hwrite(20'h50000, 16'h5555);
    check8("R3 locked block error", status, 8'h90);
    repeat (10) @(negedge clk);
    check8("R3 locked no writes", 8'(writes_seen - ws), 8'h00);
    hwrite(20'h00000, 16'h0050);
    check8("R10 clear after lock", status, 8'h80);

    // misaligned start
    enter(20'h20000);
    hwrite(20'h20003, 16'h6666);
    check8("R3 misaligned error", status, 8'h90);
    hwrite(20'h00000, 16'h0050);

    // retry exhaustion: 4 writes then error
    enter(20'h10000);
    for (int k = 0; k < 4; k++) exp_q.push_back({20'h10000, 16'h9000});
    fault_addr = 20'h10000;
    fault_left = 10;
    for (int i = 0; i < 32; i++) hwrite(20'h10000, 16'h9000 + 16'(i));
    wait_ready();
    check8("R7 retry limit error", status, 8'h90);
    repeat (20) @(negedge clk);
    fault_left = 0;
    check8("R7 no writes pending", 8'(exp_q.size()), 8'h00);
    check8("R7 idle after abort", status, 8'h90);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule